// File: doc/BRIEF.md
# Configurable SPI Transfer Engine

This block is a serial shift engine that acts either as the clock-generating master or as a selected slave on an SPI link. Each frame is 8 or 16 bits, chosen at run time, and is sent most significant bit first with mode 0 timing: data is sampled on the rising SCK edge and changes on the falling edge. A single-wire mode lets one data pin carry both directions. A separate enable bit sets whether that pin drives.

The surrounding logic supplies static control bits, a transmit word and a start strobe. It reads back a received word and a one-cycle completion pulse. Every pad-level signal has its own value and output-enable. In master mode the engine protects itself in two ways. A change to the frame width, the fault-enable bit or the single-wire bit drops the frame in flight. While single-wire mode is on, a change to the pin-direction bit does the same. A low level on the select line while fault detection is on latches a fault, and the engine then lets go of the link. When a wait-stop bit is set, an external wait input freezes the generated clock.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, sck_out, done, fault and sck_oe are all 0 while ctl_enable is 0.
- R2: With ctl_wide = 0 a master frame is 8 bits. tx_word[7:0] goes out MSB first on MOSI. The received byte appears in rx_word[7:0] with rx_word[15:8] = 0, and done is high for exactly one cycle.
- R3: With ctl_wide = 1 a master frame is 16 bits. tx_word[15] goes out first, and all 16 received bits appear in rx_word.
- R4: Mode 0 timing. MOSI holds its value for the whole time SCK is high. Each SCK half period lasts DIV_HALF system clocks, so rising edges are 2*DIV_HALF clocks apart.
- R5: During a master frame, a change of ctl_wide, ctl_fault_en or ctl_bidir forces sck_out to 0 by the next clock edge. The frame is dropped and no done pulse follows. The next start runs a normal frame.
- R6: During a master frame with ctl_bidir = 1, a change of ctl_bidir_oe aborts the frame as in R5. With ctl_bidir = 0, the same change has no effect and the frame completes with correct data.
- R7: In master mode with ctl_fault_en = 1, a low ss_in sets fault. While fault is 1, sck_oe and mosi_oe are 0. fault stays set after ss_in returns high and clears only when ctl_master is 0. With ctl_fault_en = 0, ss_in is ignored in master mode.
- R8: In normal pin mode (ctl_bidir = 0), a master has mosi_oe = 1, miso_oe = 0 and sck_oe = 1. A slave selected by ss_in = 0 has miso_oe = 1 and mosi_oe = 0. mosi_oe and miso_oe are never both 1.
- R9: In single-wire master mode (ctl_bidir = 1), miso_oe = 0 and mosi_oe equals ctl_bidir_oe. Received data is taken from mosi_in, and miso_in is ignored.
- R10: In single-wire slave mode, mosi_oe = 0 and miso_oe equals ctl_bidir_oe while selected. Received data is taken from miso_in.
- R11: With ctl_wait_stop = 1 and wait_mode = 1, sck_out is frozen and the frame resumes intact when wait_mode falls. With ctl_wait_stop = 0, wait_mode does not slow the frame.
- R12: As a slave selected by ss_in = 0, the engine loads tx_word when select falls and shifts it out MSB first on miso_out. It samples the data pin on the rising edges of sck_in and pulses done after the last falling edge of the frame.
- R13: A tx_start pulse during a master frame is ignored. The frame in flight finishes with its original data and a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Engine enable |
| ctl_master | input | 1 | 1 = master, 0 = slave |
| ctl_wide | input | 1 | 0 = 8-bit frame, 1 = 16-bit frame |
| ctl_fault_en | input | 1 | Master watches select for a fault |
| ctl_bidir | input | 1 | Single-wire data pin mode |
| ctl_bidir_oe | input | 1 | Drive enable of the single data pin |
| ctl_wait_stop | input | 1 | Freeze clock generation in wait |
| wait_mode | input | 1 | System wait state |
| tx_word | input | 16 | Word to transmit |
| tx_start | input | 1 | Master frame start strobe |
| rx_word | output | 16 | Last received frame |
| done | output | 1 | One-cycle frame completion pulse |
| fault | output | 1 | Sticky mode fault |
| sck_in | input | 1 | Serial clock from the pad |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Serial clock drive enable |
| ss_in | input | 1 | Active-low select from the pad |
| mosi_in | input | 1 | MOSI pad input |
| mosi_out | output | 1 | MOSI pad value |
| mosi_oe | output | 1 | MOSI drive enable |
| miso_in | input | 1 | MISO pad input |
| miso_out | output | 1 | MISO pad value |
| miso_oe | output | 1 | MISO drive enable |

## Verification
Most internal faults in this engine show up quickly at the pins. A wrong bit counter shows as a done pulse one SCK period early or late, or as a received word shifted by one position. A wrong choice of lead bit corrupts the first MOSI bit captured at the first rising edge. If the abort or fault logic is broken, sck_out keeps toggling one clock after the control change, or an unexpected done pulse reaches the scoreboard several SCK periods later. A bad wait gate shows as sck_out moving during the frozen window, and bad pin routing shows at once as a wrong output-enable or a received word built from the unused pin.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(WORD_W);

  // bit that goes out first for the active frame width
  function automatic logic lead_bit(logic [WORD_W-1:0] w, logic wide);
    return wide ? w[WORD_W-1] : w[BYTE_W-1];
  endfunction

  // index of the final bit of a frame
  function automatic logic [IDX_W-1:0] last_index(logic wide);
    return wide ? IDX_W'(WORD_W-1) : IDX_W'(BYTE_W-1);
  endfunction

  // received data as seen by software: narrow frames are zero extended
  function automatic logic [WORD_W-1:0] frame_view(logic [WORD_W-1:0] w, logic wide);
    return wide ? w : {{(WORD_W-BYTE_W){1'b0}}, w[BYTE_W-1:0]};
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic half_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  assign half_tick = run && (cnt == CW'(HALF-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cnt <= '0;
    else if (clear || half_tick) cnt <= '0;
    else if (run)                cnt <= cnt + 1'b1;

  // a frozen divider must not creep forward (R11)
  p_frozen_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              sample_en,
  input  logic              sample_bit,
  input  logic              shift_en,
  input  logic              wide,
  output logic              tx_bit,
  output logic [WORD_W-1:0] word_next
);
  logic [WORD_W-1:0] sh;
  logic              sbit;

  assign word_next = {sh[WORD_W-2:0], sbit};
  assign tx_bit    = lead_bit(sh, wide);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh   <= '0;
      sbit <= 1'b0;
    end else begin
      if (load)           sh <= load_val;
      else if (shift_en)  sh <= word_next;
      if (sample_en)      sbit <= sample_bit;
    end

  // the first bit after a load is the lead bit of the loaded word (R2, R3)
  p_load_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!$stable(wide) || tx_bit == lead_bit($past(load_val), wide)));
endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route (
  input  logic as_master,
  input  logic slave_sel,
  input  logic bidir,
  input  logic bidir_oe,
  input  logic tx_bit,
  input  logic mosi_raw,
  input  logic miso_raw,
  input  logic mosi_sync,
  input  logic miso_sync,
  output logic mosi_out,
  output logic mosi_oe,
  output logic miso_out,
  output logic miso_oe,
  output logic rx_bit
);
  assign mosi_out = tx_bit;
  assign miso_out = tx_bit;

  always_comb begin
    if (as_master) begin
      mosi_oe = bidir ? bidir_oe : 1'b1;
      miso_oe = 1'b0;
      rx_bit  = bidir ? mosi_raw : miso_raw;
    end else begin
      mosi_oe = 1'b0;
      miso_oe = slave_sel & (bidir ? bidir_oe : 1'b1);
      rx_bit  = bidir ? miso_sync : mosi_sync;
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DIV_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_master,
  input  logic              ctl_wide,
  input  logic              ctl_fault_en,
  input  logic              ctl_bidir,
  input  logic              ctl_bidir_oe,
  input  logic              ctl_wait_stop,
  input  logic              wait_mode,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_start,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              fault,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              ss_in,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe
);
  // ---------------- pad synchronisers ----------------
  logic [3:0] sync_q;
  logic sck_s, ss_s, mosi_s, miso_s;
  spi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_in, ss_in, mosi_in, miso_in}), .q(sync_q));
  assign {sck_s, ss_s, mosi_s, miso_s} = sync_q;

  // ---------------- mode fault ----------------
  logic fault_q, fault_set, eff_master, slave_mode, slave_sel;
  assign fault_set  = ctl_enable & ctl_master & ctl_fault_en & ~ss_s;
  assign eff_master = ctl_enable & ctl_master & ~fault_q;
  assign slave_mode = ctl_enable & ~eff_master;
  assign slave_sel  = slave_mode & ~ss_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          fault_q <= 1'b0;
    else if (!ctl_master) fault_q <= 1'b0;
    else if (fault_set)   fault_q <= 1'b1;

  // ---------------- configuration change watch ----------------
  logic prev_wide, prev_fen, prev_bidir, prev_oe, cfg_change;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {prev_wide, prev_fen, prev_bidir, prev_oe} <= '0;
    else        {prev_wide, prev_fen, prev_bidir, prev_oe} <=
                {ctl_wide, ctl_fault_en, ctl_bidir, ctl_bidir_oe};

  assign cfg_change = (ctl_wide != prev_wide) | (ctl_fault_en != prev_fen) |
                      (ctl_bidir != prev_bidir) |
                      (ctl_bidir & (ctl_bidir_oe != prev_oe));

  // ---------------- master sequencing ----------------
  logic m_busy, sck_q, gated, half_tick;
  logic [IDX_W-1:0] m_cnt;
  logic abort_evt, m_start, m_rise, m_fall, m_last;

  assign gated     = ctl_wait_stop & wait_mode;
  assign abort_evt = m_busy & (cfg_change | ~eff_master);
  assign m_start   = tx_start & eff_master & ~m_busy;
  assign m_rise    = m_busy & ~abort_evt & half_tick & ~sck_q;
  assign m_fall    = m_busy & ~abort_evt & half_tick & sck_q;
  assign m_last    = m_fall & (m_cnt == last_index(ctl_wide));

  spi_clk_div #(.HALF(DIV_HALF)) i_div (
    .clk(clk), .rst_n(rst_n), .run(m_busy & ~gated), .clear(~m_busy),
    .half_tick(half_tick));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_busy <= 1'b0; sck_q <= 1'b0; m_cnt <= '0;
    end else if (abort_evt) begin
      m_busy <= 1'b0; sck_q <= 1'b0; m_cnt <= '0;
    end else if (m_start) begin
      m_busy <= 1'b1; sck_q <= 1'b0; m_cnt <= '0;
    end else if (m_rise) begin
      sck_q <= 1'b1;
    end else if (m_fall) begin
      sck_q <= 1'b0;
      if (m_last) begin
        m_busy <= 1'b0; m_cnt <= '0;
      end else begin
        m_cnt <= m_cnt + 1'b1;
      end
    end

  // ---------------- slave sequencing ----------------
  logic ss_prev, sck_prev, s_load, s_rise, s_fall, s_last;
  logic [IDX_W-1:0] s_cnt;

  assign s_load = slave_sel & ss_prev;
  assign s_rise = slave_sel & sck_s & ~sck_prev;
  assign s_fall = slave_sel & ~sck_s & sck_prev;
  assign s_last = s_fall & (s_cnt == last_index(ctl_wide));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ss_prev <= 1'b1; sck_prev <= 1'b0; s_cnt <= '0;
    end else begin
      ss_prev  <= ss_s;
      sck_prev <= sck_s;
      if (!slave_sel)  s_cnt <= '0;
      else if (s_fall) s_cnt <= s_last ? '0 : s_cnt + 1'b1;
    end

  // ---------------- datapath ----------------
  logic tx_bit, rx_bit, frame_end;
  logic [WORD_W-1:0] word_next;

  spi_shifter i_shift (
    .clk(clk), .rst_n(rst_n), .load(m_start | s_load), .load_val(tx_word),
    .sample_en(m_rise | s_rise), .sample_bit(rx_bit),
    .shift_en(m_fall | s_fall), .wide(ctl_wide),
    .tx_bit(tx_bit), .word_next(word_next));

  spi_pin_route i_route (
    .as_master(eff_master), .slave_sel(slave_sel), .bidir(ctl_bidir),
    .bidir_oe(ctl_bidir_oe), .tx_bit(tx_bit), .mosi_raw(mosi_in),
    .miso_raw(miso_in), .mosi_sync(mosi_s), .miso_sync(miso_s),
    .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_out(miso_out),
    .miso_oe(miso_oe), .rx_bit(rx_bit));

  assign frame_end = m_last | s_last;

  logic done_q;
  logic [WORD_W-1:0] rx_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_q <= 1'b0; rx_q <= '0;
    end else begin
      done_q <= frame_end;
      if (frame_end) rx_q <= frame_view(word_next, ctl_wide);
    end

  assign rx_word = rx_q;
  assign done    = done_q;
  assign fault   = fault_q;
  assign sck_out = sck_q;
  assign sck_oe  = eff_master;

  // ---------------- assertions ----------------
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_out && $past(sck_out)) |-> $stable(mosi_out));
  p_abort_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!sck_out && !done));
  p_fault_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!sck_oe && !mosi_oe));
  p_pins_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mosi_oe && miso_oe));
  p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_busy && gated && !abort_evt) |=> $stable(sck_out));
endmodule

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ctl_enable = 0, ctl_master = 0, ctl_wide = 0, ctl_fault_en = 0;
  logic ctl_bidir = 0, ctl_bidir_oe = 0, ctl_wait_stop = 0, wait_mode = 0;
  logic [15:0] tx_word = '0;
  logic tx_start = 0, sck_in = 0, ss_in = 1, mosi_in = 0, miso_in = 0;
  logic [15:0] rx_word;
  logic done, fault, sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

  spi_xfer_engine i_spi_xfer_engine (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_master(ctl_master),
    .ctl_wide(ctl_wide), .ctl_fault_en(ctl_fault_en), .ctl_bidir(ctl_bidir),
    .ctl_bidir_oe(ctl_bidir_oe), .ctl_wait_stop(ctl_wait_stop),
    .wait_mode(wait_mode), .tx_word(tx_word), .tx_start(tx_start),
    .rx_word(rx_word), .done(done), .fault(fault), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .ss_in(ss_in), .mosi_in(mosi_in),
    .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_in(miso_in),
    .miso_out(miso_out), .miso_oe(miso_oe));

  int n_checks = 0, n_fail = 0, done_cnt = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] bview(logic [15:0] w, logic wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  // bench-side peer slave used for master frames
  logic [15:0] mdl_sh = '0;
  logic mdl_wide = 0, mdl_bidir = 0;
  logic [15:0] cap = '0;
  time rise_last = 0, rise_prev = 0;

  task automatic mdl_drive();
    logic b;
    b = mdl_wide ? mdl_sh[15] : mdl_sh[7];
    if (mdl_bidir) begin mosi_in = b; miso_in = ~b; end
    else           begin miso_in = b; mosi_in = 1'b0; end
  endtask

  initial forever begin
    @(negedge sck_out);
    mdl_sh = mdl_sh << 1;
    mdl_drive();
  end

  initial forever begin
    @(posedge sck_out);
    cap = {cap[14:0], mosi_out};
    rise_prev = rise_last;
    rise_last = $time;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (done) begin
      done_cnt++;
      if (exp_q.size() == 0) check(1'b0, "scoreboard unexpected done", rx_word, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rx_word == e, t, rx_word, e);
      end
    end
  end

  // poke: 0 none, 1 toggle bidir_oe, 2 extra start, 3 wait stall
  task automatic master_run(logic [15:0] tx, logic [15:0] resp, int poke,
                            string tag, output int cycles);
    int d0;
    mdl_sh = resp; mdl_wide = ctl_wide; mdl_bidir = ctl_bidir; mdl_drive();
    cap = '0;
    exp_q.push_back(bview(resp, ctl_wide)); tag_q.push_back(tag);
    d0 = done_cnt;
    tx_word = tx; tx_start = 1; @(negedge clk); tx_start = 0;
    cycles = 1;
    if (poke != 0) begin
      repeat (6) @(negedge clk);
      cycles += 6;
      if (poke == 1) ctl_bidir_oe = ~ctl_bidir_oe;
      if (poke == 2) begin
        tx_word = ~tx; tx_start = 1; @(negedge clk); tx_start = 0; cycles++;
      end
      if (poke == 3) begin
        logic s;
        wait_mode = 1; @(negedge clk); s = sck_out;
        repeat (20) @(negedge clk);
        check(sck_out == s, "R11 sck frozen in wait", 16'(sck_out), 16'(s));
        check(done_cnt == d0, "R11 no done while frozen", 16'(done_cnt), 16'(d0));
        wait_mode = 0;
      end
    end
    while (done_cnt == d0 && cycles < 400) begin @(negedge clk); cycles++; end
    check(done_cnt == d0 + 1, {tag, " single done"}, 16'(done_cnt - d0), 16'd1);
    check(bview(cap, ctl_wide) == bview(tx, ctl_wide), {tag, " mosi bits"},
          bview(cap, ctl_wide), bview(tx, ctl_wide));
    repeat (3) @(negedge clk);
  endtask

  // kind: 0 width, 1 single-wire bit, 2 direction bit
  task automatic abort_run(int kind, string tag);
    int d0;
    mdl_sh = 16'hFFFF; mdl_wide = ctl_wide; mdl_bidir = ctl_bidir; mdl_drive();
    tx_word = 16'h5555; tx_start = 1; @(negedge clk); tx_start = 0;
    @(posedge sck_out); @(negedge clk);
    d0 = done_cnt;
    if (kind == 0) ctl_wide = ~ctl_wide;
    if (kind == 1) ctl_bidir = ~ctl_bidir;
    if (kind == 2) ctl_bidir_oe = ~ctl_bidir_oe;
    @(negedge clk);
    check(sck_out == 1'b0, {tag, " sck low next cycle"}, 16'(sck_out), 16'h0);
    repeat (80) @(negedge clk);
    check(done_cnt == d0, {tag, " no done after abort"}, 16'(done_cnt), 16'(d0));
    if (kind == 0) ctl_wide = ~ctl_wide;
    if (kind == 1) ctl_bidir = ~ctl_bidir;
    if (kind == 2) ctl_bidir_oe = ~ctl_bidir_oe;
    repeat (3) @(negedge clk);
  endtask

  // bench acts as master toward the engine in slave mode
  task automatic slave_run(logic [15:0] tx, logic [15:0] mpat, string tag);
    int d0, nb;
    logic [15:0] scap;
    logic exp_oe;
    scap = '0;
    nb = ctl_wide ? 16 : 8;
    tx_word = tx;
    exp_q.push_back(bview(mpat, ctl_wide)); tag_q.push_back(tag);
    d0 = done_cnt;
    ss_in = 0;
    repeat (6) @(negedge clk);
    exp_oe = ctl_bidir ? ctl_bidir_oe : 1'b1;
    check(miso_oe == exp_oe, {tag, " miso_oe selected"}, 16'(miso_oe), 16'(exp_oe));
    check(mosi_oe == 1'b0, {tag, " mosi_oe slave"}, 16'(mosi_oe), 16'h0);
    for (int i = nb - 1; i >= 0; i--) begin
      if (ctl_bidir) begin miso_in = mpat[i]; mosi_in = ~mpat[i]; end
      else           begin mosi_in = mpat[i]; miso_in = ~mpat[i]; end
      repeat (6) @(negedge clk);
      sck_in = 1;
      repeat (3) @(negedge clk);
      scap = {scap[14:0], miso_out};
      repeat (3) @(negedge clk);
      sck_in = 0;
    end
    repeat (8) @(negedge clk);
    ss_in = 1;
    repeat (4) @(negedge clk);
    check(done_cnt == d0 + 1, {tag, " single done"}, 16'(done_cnt - d0), 16'd1);
    if (exp_oe)
      check(bview(scap, ctl_wide) == bview(tx, ctl_wide), {tag, " miso bits"},
            bview(scap, ctl_wide), bview(tx, ctl_wide));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 16'h0, 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(sck_out == 0, "R1 sck_out reset", 16'(sck_out), 16'h0);
    check(done == 0, "R1 done reset", 16'(done), 16'h0);
    check(fault == 0, "R1 fault reset", 16'(fault), 16'h0);
    check(sck_oe == 0, "R1 sck_oe disabled", 16'(sck_oe), 16'h0);

    // R8 master normal routing
    ctl_enable = 1; ctl_master = 1;
    @(negedge clk);
    check(mosi_oe == 1 && miso_oe == 0 && sck_oe == 1, "R8 master pins",
          {13'h0, sck_oe, mosi_oe, miso_oe}, 16'h0006);

    // R2 8-bit frames, R4 timing
    master_run(16'hAB5A, 16'h00C3, 0, "R2 8-bit rx a", cyc);
    check((rise_last - rise_prev) == 32, "R4 sck period ns",
          16'(rise_last - rise_prev), 16'd32);
    master_run(16'h0081, 16'hFF7E, 0, "R2 8-bit rx b", cyc);

    // R3 16-bit frames
    ctl_wide = 1; @(negedge clk);
    master_run(16'hA55A, 16'h1234, 0, "R3 16-bit rx a", cyc);
    master_run(16'h8001, 16'hFFFE, 0, "R3 16-bit rx b", cyc);

    // R13 start ignored while busy
    master_run(16'h0F0F, 16'h3C3C, 2, "R13 restart ignored", cyc);

    // R5 aborts on width and single-wire bit changes
    abort_run(0, "R5 width change");
    master_run(16'h1357, 16'h2468, 0, "R5 frame after abort", cyc);
    abort_run(1, "R5 bidir change");
    ctl_wide = 0; @(negedge clk);

    // R6 direction bit ignored in normal mode
    master_run(16'h00E1, 16'h001E, 1, "R6 oe toggle no abort", cyc);

    // R9 single-wire master
    ctl_bidir = 1; ctl_bidir_oe = 0; @(negedge clk); @(negedge clk);
    check(mosi_oe == 0 && miso_oe == 0, "R9 input direction",
          {14'h0, mosi_oe, miso_oe}, 16'h0);
    master_run(16'h0011, 16'h00EF, 0, "R9 rx from mosi_in", cyc);
    ctl_bidir_oe = 1; @(negedge clk); @(negedge clk);
    check(mosi_oe == 1 && miso_oe == 0, "R9 output direction",
          {14'h0, mosi_oe, miso_oe}, 16'h0002);
    abort_run(2, "R6 oe change in bidir");
    ctl_bidir = 0; ctl_bidir_oe = 0; @(negedge clk); @(negedge clk);

    // R11 wait gating
    ctl_wait_stop = 1;
    master_run(16'h00A6, 16'h0059, 3, "R11 resume after wait", cyc);
    ctl_wait_stop = 0; wait_mode = 1;
    master_run(16'h0033, 16'h00CC, 0, "R11 wait without stop", cyc);
    check(cyc <= 40, "R11 no slowdown cycles", 16'(cyc), 16'd40);
    wait_mode = 0;

    // R7 mode fault
    ctl_fault_en = 1; @(negedge clk); @(negedge clk);
    ss_in = 0; repeat (5) @(negedge clk);
    check(fault == 1, "R7 fault set", 16'(fault), 16'h1);
    check(sck_oe == 0 && mosi_oe == 0, "R7 outputs released",
          {14'h0, sck_oe, mosi_oe}, 16'h0);
    ss_in = 1; repeat (5) @(negedge clk);
    check(fault == 1, "R7 fault sticky", 16'(fault), 16'h1);
    ctl_master = 0; @(negedge clk);
    check(fault == 0, "R7 fault cleared", 16'(fault), 16'h0);
    ctl_master = 1; ctl_fault_en = 0; @(negedge clk); @(negedge clk);
    ss_in = 0; repeat (5) @(negedge clk);
    check(fault == 0 && sck_oe == 1, "R7 ss ignored",
          {14'h0, fault, sck_oe}, 16'h0001);
    master_run(16'h0072, 16'h008D, 0, "R7 frame with ss low", cyc);
    ss_in = 1; repeat (4) @(negedge clk);

    // R12 slave frames, R8 slave routing
    ctl_master = 0; repeat (3) @(negedge clk);
    slave_run(16'h0096, 16'h0069, "R12 slave 8-bit");
    ctl_wide = 1; @(negedge clk); @(negedge clk);
    slave_run(16'hC3A5, 16'h5AF0, "R12 slave 16-bit");

    // R10 single-wire slave
    ctl_bidir = 1; ctl_bidir_oe = 1; @(negedge clk); @(negedge clk);
    slave_run(16'h9E01, 16'h7B2C, "R10 bidir slave out");
    ctl_bidir_oe = 0; @(negedge clk); @(negedge clk);
    slave_run(16'h0000, 16'hE4D1, "R10 bidir slave in");

    check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule